// File: doc/BRIEF.md
# Multi-port packet transmit link controller

This block is the master end of a byte-wide, multi-port packet transmit link. A poll address bus steps through the PHY ports one per clock without pause. The one-bit poll answer from the addressed port tells the controller whether that port can take a block of data, and the controller keeps the latest answer for each port. To open a transfer, the controller picks a ready port in round-robin order. It puts that port's address on the data bus with a select strobe for one cycle, and from the next cycle it streams packet bytes with the transfer enable high.

Packet bytes come from an internal source that keeps its own progress for each port. The bytes are marked with start-of-packet, end-of-packet and error strobes. The selected port reports free space on a separate flag. When that flag drops, the controller sends a bounded number of further bytes and then releases the port. In the same cycle it can select the next ready port. A packet cut short in this way continues later from the byte where it stopped, and that continuation carries no new start strobe. Polling goes on while transfers run.

Top module: `pkt_tx_link`

## Requirements
- R1: `poll_addr` counts 0, 1, …, NPORTS-1 and wraps, advancing every clock including during transfers. The `poll_avail` value seen in a cycle is stored as the ready bit of the port addressed in that cycle.
- R2: A select cycle has `tx_sel`=1, `tx_en`=0 and `tx_data` = the port number zero-extended. A port is selected only if its stored ready bit is set, and selecting it clears that bit. The clear wins over a poll answer stored at the same edge.
- R3: The cycle after a select cycle always carries a byte, with `tx_sel`=0 and `tx_en`=1.
- R4: `tx_sop` is 1 only on byte index 0 of a packet and only while `tx_en`=1. A packet resumed after an interrupted transfer continues at its next byte index without `tx_sop`.
- R5: A transfer sends at most RUNON bytes in cycles where `sel_space`=0. The cycle after the RUNON-th such byte has `tx_en`=0. While the count stays below RUNON, bytes continue.
- R6: Packets from port p are MIN_LEN+p bytes long. `tx_eop` marks the last byte, and the transfer ends after it. `tx_err`=1 only together with `tx_eop`, on packet numbers n (counted per port from 0) where n mod ERR_EVERY = ERR_EVERY-1.
- R7: In the first cycle with `tx_en` low after a transfer, if any ready bit is set, that cycle is a select cycle for the next port.
- R8: The selected port is the first port with its ready bit set, searching upward with wrap from the port after the last one selected. After reset the search starts at port 0.
- R9: Byte k of a packet from port p is sent as p in the upper AW bits of `tx_data` and k in the lower DW-AW bits.
- R10: With `rst` high at a clock edge (synchronous), the edge clears `tx_en`, `tx_sel`, `tx_sop`, `tx_eop`, `tx_err`, `tx_data`, `poll_addr` and all ready bits.
- R11: With no transfer running and no ready bit set, `tx_en`, `tx_sel` and `tx_data` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| poll_addr | output | AW | Address of the port being polled |
| poll_avail | input | 1 | Polled port can accept a block |
| sel_space | input | 1 | Selected port still has space |
| tx_data | output | DW | Port address in select cycles, packet byte in transfer cycles |
| tx_sel | output | 1 | Port select strobe |
| tx_en | output | 1 | Transfer enable, a byte is valid |
| tx_sop | output | 1 | First byte of a packet |
| tx_eop | output | 1 | Last byte of a packet |
| tx_err | output | 1 | Packet is errored, valid with tx_eop |

## Verification
The hardest situation to reach is a port being released part-way through a packet and later resumed from the byte where it stopped. The same run should also show a poll answer and a selection clear landing on the same ready bit in one edge. A directed phase makes one port the only ready port, lowers its space flag in the middle of a packet for several cycles, and then raises it again. That phase forces the run-on cut and the resumption without a start strobe. A long pseudo-random phase then varies the poll answers and the space flags of all ports every cycle, and a reset in mid-run repeats it from a clean state. A behavioural model is compared with the outputs on every clock.

// File: rtl/pkt_tx_link.sv
module pkt_tx_link #(
  parameter int NPORTS    = 4,
  parameter int AW        = 2,
  parameter int DW        = 8,
  parameter int MIN_LEN   = 6,
  parameter int RUNON     = 2,
  parameter int ERR_EVERY = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] poll_addr,
  input  logic          poll_avail,
  input  logic          sel_space,
  output logic [DW-1:0] tx_data,
  output logic          tx_sel,
  output logic          tx_en,
  output logic          tx_sop,
  output logic          tx_eop,
  output logic          tx_err
);
  localparam int LW  = $clog2(MIN_LEN + NPORTS + 1);
  localparam int EW  = $clog2(ERR_EVERY + 1);
  localparam int RW  = $clog2(RUNON + 1);
  localparam int LOW = DW - AW;

  logic [NPORTS-1:0] ready;
  logic [LW-1:0]     pos  [NPORTS];
  logic [EW-1:0]     pkts [NPORTS];
  logic [AW-1:0]     cur, last, pick;
  logic [RW-1:0]     lowc;
  logic              found;

  wire        gap      = !sel_space;
  wire [RW:0] low_next = {1'b0, lowc} + {{RW{1'b0}}, gap};
  wire        keep     = tx_en && !tx_eop && (int'(low_next) < RUNON);
  wire        issue    = tx_sel || keep;
  wire        is_last  = pos[cur] == LW'(MIN_LEN + int'(cur) - 1);
  wire        is_err   = is_last && (pkts[cur] == EW'(ERR_EVERY - 1));

  always_comb begin
    found = 1'b0;
    pick  = last;
    for (int k = 1; k <= NPORTS; k++) begin
      if (!found && ready[(int'(last) + k) % NPORTS]) begin
        found = 1'b1;
        pick  = AW'((int'(last) + k) % NPORTS);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      poll_addr <= '0;
      ready     <= '0;
      cur       <= '0;
      last      <= AW'(NPORTS - 1);
      lowc      <= '0;
      tx_data   <= '0;
      tx_sel    <= 1'b0;
      tx_en     <= 1'b0;
      tx_sop    <= 1'b0;
      tx_eop    <= 1'b0;
      tx_err    <= 1'b0;
      for (int p = 0; p < NPORTS; p++) begin
        pos[p]  <= '0;
        pkts[p] <= '0;
      end
    end else begin
      poll_addr <= (poll_addr == AW'(NPORTS - 1)) ? '0 : poll_addr + 1'b1;
      ready[poll_addr] <= poll_avail;
      if (issue) begin
        tx_en   <= 1'b1;
        tx_sel  <= 1'b0;
        tx_sop  <= pos[cur] == '0;
        tx_eop  <= is_last;
        tx_err  <= is_err;
        tx_data <= {cur, LOW'(pos[cur])};
        lowc    <= tx_en ? RW'(low_next) : '0;
        pos[cur] <= is_last ? '0 : pos[cur] + 1'b1;
        if (is_last)
          pkts[cur] <= (pkts[cur] == EW'(ERR_EVERY - 1)) ? '0 : pkts[cur] + 1'b1;
      end else begin
        tx_en  <= 1'b0;
        tx_sop <= 1'b0;
        tx_eop <= 1'b0;
        tx_err <= 1'b0;
        lowc   <= '0;
        if (found) begin
          tx_sel      <= 1'b1;
          tx_data     <= DW'(pick);
          cur         <= pick;
          last        <= pick;
          ready[pick] <= 1'b0;
        end else begin
          tx_sel  <= 1'b0;
          tx_data <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_tx_link_chk.sv
module pkt_tx_link_chk #(
  parameter int NPORTS = 4,
  parameter int AW     = 2,
  parameter int RUNON  = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] poll_addr,
  input logic          sel_space,
  input logic          tx_sel,
  input logic          tx_en,
  input logic          tx_sop,
  input logic          tx_eop,
  input logic          tx_err
);
  int cnt;

  always_ff @(posedge clk) begin
    if (rst || !tx_en) cnt <= 0;
    else if (!sel_space) cnt <= cnt + 1;
  end

  assert_poll_step_R1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> poll_addr == AW'((int'($past(poll_addr)) + 1) % NPORTS));
  assert_sel_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(tx_sel && tx_en));
  assert_sel_then_byte_R3: assert property (@(posedge clk) disable iff (rst)
    tx_sel |=> tx_en && !tx_sel);
  assert_sop_in_xfer_R4: assert property (@(posedge clk) disable iff (rst)
    tx_sop |-> tx_en);
  assert_sop_first_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !tx_eop) |=> !tx_sop);
  assert_runon_cap_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !sel_space) |-> cnt < RUNON);
  assert_runon_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !sel_space && cnt == RUNON - 1) |=> !tx_en);
  assert_err_eop_R6: assert property (@(posedge clk) disable iff (rst)
    tx_err |-> tx_eop);
  assert_eop_ends_R6: assert property (@(posedge clk) disable iff (rst)
    tx_eop |=> !tx_en);
  assert_reset_R10: assert property (@(posedge clk)
    rst |=> !tx_en && !tx_sel && !tx_sop && !tx_eop && !tx_err && poll_addr == '0);
endmodule

bind pkt_tx_link pkt_tx_link_chk #(.NPORTS(NPORTS), .AW(AW), .RUNON(RUNON)) u_chk (
  .clk(clk), .rst(rst), .poll_addr(poll_addr), .sel_space(sel_space),
  .tx_sel(tx_sel), .tx_en(tx_en), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_err(tx_err)
);

// File: tb/pkt_tx_link_tb.sv
module pkt_tx_link_tb;
  localparam int N = 4, AW = 2, DW = 8, MIN_LEN = 6, RUNON = 2, ERR_EVERY = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] poll_addr;
  logic [DW-1:0] tx_data;
  logic tx_sel, tx_en, tx_sop, tx_eop, tx_err;
  logic [N-1:0] pxa_vec = '0, spa_vec = '1;
  int phy_sel = 0;
  wire poll_avail = pxa_vec[poll_addr];
  wire sel_space  = spa_vec[phy_sel];

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pkt_tx_link #(.NPORTS(N), .AW(AW), .DW(DW), .MIN_LEN(MIN_LEN), .RUNON(RUNON),
    .ERR_EVERY(ERR_EVERY)) u_dut (
    .clk(clk), .rst(rst), .poll_addr(poll_addr), .poll_avail(poll_avail),
    .sel_space(sel_space), .tx_data(tx_data), .tx_sel(tx_sel), .tx_en(tx_en),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_err(tx_err));

  // behavioural reference state
  int m_addr, m_cur, m_last, m_lowc, m_data;
  int m_ready[N], m_pos[N], m_pkt[N];
  bit m_en, m_sel, m_sop, m_eop, m_err, m_valid = 0, prev_en, prev_sel;
  int since_rst = 0;

  task automatic cmp(string tag, string name, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_addr = 0; m_cur = 0; m_last = N - 1; m_lowc = 0; m_data = 0;
    m_en = 0; m_sel = 0; m_sop = 0; m_eop = 0; m_err = 0;
    prev_en = 0; prev_sel = 0;
    for (int p = 0; p < N; p++) begin m_ready[p] = 0; m_pos[p] = 0; m_pkt[p] = 0; end
    m_valid = 1; since_rst = 0;
  endtask

  task automatic model_step(bit pxa, bit spa);
    int lown, pk; bit keep, issue, fnd, lastb;
    lown  = m_lowc + (spa ? 0 : 1);
    keep  = m_en && !m_eop && (lown < RUNON);
    issue = m_sel || keep;
    fnd = 0; pk = m_last;
    for (int k = 1; k <= N; k++)
      if (!fnd && m_ready[(m_last + k) % N] != 0) begin fnd = 1; pk = (m_last + k) % N; end
    m_ready[m_addr] = pxa;
    m_addr = (m_addr + 1) % N;
    prev_en = m_en; prev_sel = m_sel;
    if (issue) begin
      lastb  = m_pos[m_cur] == MIN_LEN + m_cur - 1;
      m_sop  = m_pos[m_cur] == 0;
      m_eop  = lastb;
      m_err  = lastb && (m_pkt[m_cur] == ERR_EVERY - 1);
      m_data = m_cur * (1 << (DW - AW)) + m_pos[m_cur];
      m_lowc = m_en ? lown : 0;
      m_en = 1; m_sel = 0;
      m_pos[m_cur] = lastb ? 0 : m_pos[m_cur] + 1;
      if (lastb) m_pkt[m_cur] = (m_pkt[m_cur] + 1) % ERR_EVERY;
    end else begin
      m_en = 0; m_sop = 0; m_eop = 0; m_err = 0; m_lowc = 0;
      if (fnd) begin
        m_sel = 1; m_data = pk; m_cur = pk; m_last = pk; m_ready[pk] = 0;
      end else begin
        m_sel = 0; m_data = 0;
      end
    end
  endtask

  always @(negedge clk) begin
    if (m_valid && !rst && !done) begin
      string t;
      t = (since_rst == 0) ? "R10" : "";
      cmp(since_rst == 0 ? "R10" : "R1", "poll_addr", int'(poll_addr), m_addr);
      cmp(since_rst == 0 ? "R10" : (prev_en && !m_en) ? "R7" : "R2", "tx_sel", int'(tx_sel), int'(m_sel));
      cmp(since_rst == 0 ? "R10" : prev_sel ? "R3" : "R5", "tx_en", int'(tx_en), int'(m_en));
      cmp(since_rst == 0 ? "R10" : "R4", "tx_sop", int'(tx_sop), int'(m_sop));
      cmp(since_rst == 0 ? "R10" : "R6", "tx_eop", int'(tx_eop), int'(m_eop));
      cmp(since_rst == 0 ? "R10" : "R6", "tx_err", int'(tx_err), int'(m_err));
      cmp(since_rst == 0 ? "R10" : m_sel ? "R8" : m_en ? "R9" : "R11", "tx_data", int'(tx_data), m_data);
      since_rst++;
    end
    if (rst) model_reset();
    else if (m_valid) model_step(poll_avail, sel_space);
    if (tx_sel === 1'b1) phy_sel = int'(tx_data) % N;
  end

  logic [15:0] lfsr = 16'hACE1;

  task automatic wait_cycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic run_random(int n);
    repeat (n) begin
      @(posedge clk); #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pxa_vec = lfsr[3:0];
      spa_vec = lfsr[7:4] | lfsr[11:8];
    end
  endtask

  initial begin
    wait_cycles(4);
    rst = 1'b0;
    wait_cycles(12);           // R11: nothing ready, link stays idle
    pxa_vec = 4'b0100;         // only port 2 ready: R2 R3 R6 R9
    wait_cycles(30);
    spa_vec = 4'b1011;         // R5 run-on cut, R4 resume without start strobe
    wait_cycles(5);
    spa_vec = 4'b1111;
    wait_cycles(30);
    pxa_vec = 4'b1111;         // R8 round robin, R7 switch on release
    wait_cycles(80);
    run_random(700);
    rst = 1'b1;                // R10 reset in mid-run
    wait_cycles(3);
    rst = 1'b0;
    lfsr = 16'h5A3C;
    run_random(700);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule